// File: doc/BRIEF.md
# Converter Output Formatter with Test Patterns

This block sits between the core of a data converter and its parallel output pins. On every sample clock it takes one offset-binary sample and produces the word that goes to the pins. It also produces an output clock, and the polarity of that clock tells the receiver which edge carries valid data. A two-bit test selector can replace live samples with a constant all-zeros word, a constant all-ones word, or a word that alternates between the two on every sample. Test patterns let the receiving logic check its capture path without an analog input.

A pre-decoded two-bit format code picks the number format and the valid clock edge. When two's complement is selected, the most significant bit of the word is inverted. This applies to test patterns as well as to live data, because the patterns are defined in offset-binary terms. A power-down flag blanks both the data word and the output clock.

Top module: `adc_out_formatter`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, `data_o` becomes all zeros on that edge, and the toggle phase returns to its initial state.
- R2: With `test_sel_i` = 00, the word loaded on a rising edge is the live `sample_i` present at that edge.
- R3: With `test_sel_i` = 01, the loaded word is all zeros before format conversion. With `test_sel_i` = 10, it is all ones before format conversion.
- R4: With `test_sel_i` = 11, the loaded word before format conversion alternates between all zeros and all ones. A phase bit flips on every clock edge out of reset. The first edge after reset gives all zeros, the next gives all ones, and so on.
- R5: `fmt_code_i` bit 0 selects the number format. When it is 1 (two's complement), the most significant bit of the word from R2, R3 or R4 is inverted and the other bits pass unchanged. When it is 0 (offset binary), the word passes unchanged.
- R6: `fmt_code_i` bit 1 selects the valid edge. When it is 0 (rising edge), `out_clk_o` follows `clk`. When it is 1 (falling edge), `out_clk_o` is the inverse of `clk`. The four codes are therefore 00 = offset binary, rising; 01 = two's complement, rising; 10 = offset binary, falling; 11 = two's complement, falling.
- R7: While `pwr_down_i` is high, `out_clk_o` is held low. At each rising edge where `pwr_down_i` is high, `data_o` is loaded with all zeros, whatever the test selector and format code are.
- R8: `data_o` is registered. It changes only on a rising edge of `clk` and shows the result for the inputs sampled at that edge, one sample clock of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_i | input | DATA_W | Live converter sample, offset binary |
| test_sel_i | input | 2 | 00 live, 01 zeros, 10 ones, 11 toggle |
| fmt_code_i | input | 2 | Bit 0: two's complement; bit 1: falling-edge valid |
| pwr_down_i | input | 1 | Power-down: blank data and clock |
| data_o | output | DATA_W | Formatted output word |
| out_clk_o | output | 1 | Output clock whose polarity marks the valid edge |

## Verification
`data_o` is due one rising edge after the inputs that produce it. The bench drives inputs on falling edges. A reference model updates on each rising edge, and the bench compares `data_o` with the model at the following falling edge, before it applies new stimulus. `out_clk_o` is combinational in `clk`, the format code and power-down. The bench samples it one nanosecond after each edge, once while `clk` is high and once while `clk` is low, and compares it with the level that the current inputs call for. The toggle phase is tracked by counting edges since reset, so toggle checks do not depend on when the toggle mode was entered.

// File: rtl/adc_fmt_pkg.sv
// Package: shared types for the converter output formatter.
// Assumes nothing beyond a two-bit test selector encoding.
package adc_fmt_pkg;
    typedef enum logic [1:0] {
        TEST_LIVE   = 2'b00,
        TEST_ZEROS  = 2'b01,
        TEST_ONES   = 2'b10,
        TEST_TOGGLE = 2'b11
    } test_sel_e;

    localparam int FMT_TWOS_BIT = 0;
    localparam int FMT_FALL_BIT = 1;
endpackage

// File: rtl/adc_pattern_src.sv
// Module: picks live data or a test pattern, in offset-binary terms.
// Holds the toggle phase; the phase flips on every clock edge out of reset.
// Assumes a synchronous active-low reset.
module adc_pattern_src
    import adc_fmt_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sample_i,
    input  logic [1:0]        test_sel_i,
    output logic [DATA_W-1:0] word_o
);
    localparam logic [DATA_W-1:0] ALL_ZERO = '0;
    localparam logic [DATA_W-1:0] ALL_ONE  = '1;

    logic phase_q;
    test_sel_e sel;

    assign sel = test_sel_e'(test_sel_i);

    // Toggle phase: flips every edge, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= ~phase_q;
    end

    // Source select: live sample or one of the three patterns.
    always_comb begin
        unique case (sel)
            TEST_LIVE:   word_o = sample_i;
            TEST_ZEROS:  word_o = ALL_ZERO;
            TEST_ONES:   word_o = ALL_ONE;
            TEST_TOGGLE: word_o = phase_q ? ALL_ONE : ALL_ZERO;
            default:     word_o = sample_i;
        endcase
    end
endmodule

// File: rtl/adc_num_format.sv
// Module: converts an offset-binary word to two's complement on request.
// Assumes DATA_W >= 2; purely combinational.
module adc_num_format #(
    parameter int DATA_W = 12
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic              twos_i,
    output logic [DATA_W-1:0] word_o
);
    localparam int MSB = DATA_W - 1;

    // Format conversion: invert the sign position only.
    always_comb begin
        word_o      = word_i;
        word_o[MSB] = word_i[MSB] ^ twos_i;
    end
endmodule

// File: rtl/adc_clk_polarity.sv
// Module: derives the output clock from the sample clock.
// Assumes glitches at select changes are tolerated by the pin driver.
module adc_clk_polarity (
    input  logic clk,
    input  logic fall_i,
    input  logic pwr_down_i,
    output logic out_clk_o
);
    // Polarity select with power-down gating.
    always_comb begin
        if (pwr_down_i) out_clk_o = 1'b0;
        else            out_clk_o = clk ^ fall_i;
    end
endmodule

// File: rtl/adc_out_formatter.sv
// Module: top of the converter output formatter.
// Registers the formatted word (one cycle latency) and drives the output
// clock. Assumes a synchronous active-low reset and DATA_W >= 2.
module adc_out_formatter
    import adc_fmt_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sample_i,
    input  logic [1:0]        test_sel_i,
    input  logic [1:0]        fmt_code_i,
    input  logic              pwr_down_i,
    output logic [DATA_W-1:0] data_o,
    output logic              out_clk_o
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] src_word;
    logic [DATA_W-1:0] fmt_word;
    logic [DATA_W-1:0] data_q;

    adc_pattern_src #(.DATA_W(DATA_W)) u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_i   (sample_i),
        .test_sel_i (test_sel_i),
        .word_o     (src_word)
    );

    adc_num_format #(.DATA_W(DATA_W)) u_fmt (
        .word_i (src_word),
        .twos_i (fmt_code_i[FMT_TWOS_BIT]),
        .word_o (fmt_word)
    );

    adc_clk_polarity u_clk (
        .clk        (clk),
        .fall_i     (fmt_code_i[FMT_FALL_BIT]),
        .pwr_down_i (pwr_down_i),
        .out_clk_o  (out_clk_o)
    );

    // Output register: reset and power-down clear it, else load the word.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_down_i) data_q <= '0;
        else                      data_q <= fmt_word;
    end

    assign data_o = data_q;

    a_r7_pd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down_i |=> (data_o == '0));

    a_r2_live_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_down_i && test_sel_i == 2'b00 && !fmt_code_i[0])
        |=> (data_o == $past(sample_i)));

    a_r5_live_twos: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_down_i && test_sel_i == 2'b00 && fmt_code_i[0])
        |=> (data_o == {~$past(sample_i[MSB]), $past(sample_i[MSB-1:0])}));

    a_r3_const_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_down_i && test_sel_i == 2'b01)
        |=> (data_o[MSB-1:0] == '0 && data_o[MSB] == $past(fmt_code_i[0])));

    a_r4_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_down_i && test_sel_i == 2'b11) ##1 (!pwr_down_i && test_sel_i == 2'b11)
        |=> (data_o[MSB-1:0] == ~$past(data_o[MSB-1:0])));
endmodule

// File: tb/adc_out_formatter_bench.sv
module adc_out_formatter_bench;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] sample_i = '0;
    logic [1:0]   test_sel_i = 2'b00;
    logic [1:0]   fmt_code_i = 2'b00;
    logic         pwr_down_i = 1'b0;
    logic [W-1:0] data_o;
    logic         out_clk_o;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    logic [W-1:0] exp_data = '0;
    int phase = 0;
    bit primed = 0;
    bit done = 0;

    always #4 clk = ~clk;

    adc_out_formatter #(.DATA_W(W)) u_adc_out_formatter (
        .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .test_sel_i(test_sel_i),
        .fmt_code_i(fmt_code_i), .pwr_down_i(pwr_down_i),
        .data_o(data_o), .out_clk_o(out_clk_o)
    );

    // Reference model: updates on each rising edge from the applied inputs.
    always @(posedge clk) begin
        logic [W-1:0] w;
        if (!rst_n) begin
            exp_data <= '0;
            phase    <= 0;
        end else begin
            case (test_sel_i)
                2'b00: w = sample_i;
                2'b01: w = '0;
                2'b10: w = '1;
                default: w = (phase != 0) ? '1 : '0;
            endcase
            if (fmt_code_i[0]) w[W-1] = ~w[W-1];
            if (pwr_down_i) w = '0;
            exp_data <= w;
            phase    <= 1 - phase;
        end
        primed <= 1;
    end

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Data comparison at every falling edge (R8 latency covered by timing).
    always @(negedge clk) begin
        if (primed && !done) check(cur_req, data_o, exp_data);
    end

    // Output clock checks one ns after each edge.
    always @(posedge clk) begin
        #1;
        if (!done) check(pwr_down_i ? "R7" : "R6", {{(W-1){1'b0}}, out_clk_o},
                         {{(W-1){1'b0}}, (!pwr_down_i && !fmt_code_i[1])});
    end
    always @(negedge clk) begin
        #1;
        if (!done) check(pwr_down_i ? "R7" : "R6", {{(W-1){1'b0}}, out_clk_o},
                         {{(W-1){1'b0}}, (!pwr_down_i && fmt_code_i[1])});
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        cur_req = "R1";
        step(3);
        rst_n = 1'b1;
        // R2: live data, offset binary, several patterns (R8 latency).
        cur_req = "R2";
        fmt_code_i = 2'b00;
        for (int i = 0; i < 8; i++) begin
            sample_i = W'(i * 517 + 3);
            step(1);
        end
        sample_i = 12'h800; step(1);
        sample_i = 12'h7FF; step(1);
        // R3: constant patterns, offset then two's complement.
        cur_req = "R3";
        test_sel_i = 2'b01; step(2);
        test_sel_i = 2'b10; step(2);
        cur_req = "R5";
        fmt_code_i = 2'b01;
        test_sel_i = 2'b01; step(2);
        test_sel_i = 2'b10; step(2);
        // R5: live data in two's complement.
        test_sel_i = 2'b00;
        for (int i = 0; i < 6; i++) begin
            sample_i = W'(i * 1311 + 77);
            step(1);
        end
        // R4: toggle pattern in both formats.
        cur_req = "R4";
        test_sel_i = 2'b11;
        fmt_code_i = 2'b00; step(5);
        fmt_code_i = 2'b01; step(5);
        // R6: every format code, rising and falling edge.
        cur_req = "R6";
        test_sel_i = 2'b00;
        for (int c = 0; c < 4; c++) begin
            fmt_code_i = 2'(c);
            sample_i = W'(c * 901 + 11);
            step(3);
        end
        // R7: power-down in every test mode and format.
        cur_req = "R7";
        pwr_down_i = 1'b1;
        for (int t = 0; t < 4; t++) begin
            test_sel_i = 2'(t);
            fmt_code_i = 2'(3 - t);
            sample_i = 12'hFFF;
            step(2);
        end
        pwr_down_i = 1'b0;
        cur_req = "R8";
        test_sel_i = 2'b00; fmt_code_i = 2'b00;
        sample_i = 12'hA5A; step(1);
        sample_i = 12'h5A5; step(1);
        // R1: reset mid-run clears output and toggle phase.
        cur_req = "R1";
        test_sel_i = 2'b11;
        rst_n = 1'b0; step(2);
        rst_n = 1'b1;
        cur_req = "R4";
        step(4);
        step(1);
        finish_run();
    end
endmodule